// File: doc/BRIEF.md
# Multi-Lane Marker Lock and Skew Monitor

This block sits on the receive side of a link that spreads one frame stream over a group of logical lanes, one byte per lane per clock. On every lane it hunts for the frame alignment header and declares lock once the header recurs at the expected spacing. It reads the lane marker byte that follows the header and derives the lane's logical number from it. Physical lane order is never trusted: the logical number always comes from the marker.

Each locked lane also yields an epoch: its marker value minus a shared slot count, modulo the marker cycle. The slot count advances once per frame period. Epoch differences between lanes measure relative skew in whole frame periods. The block flags skew that the marker cycle can no longer resolve, and it flags two locked lanes that claim the same logical number. A single alignment-valid flag summarizes the lane group for the deskew logic that follows.

Top module: `lane_id_skew_chk`

## Requirements
- R1: A header is the four bytes 0xF6, 0xF6, 0xF6, 0x28, then one byte that is not compared, then the marker byte. Only those first 32 bits decide a match.
- R2: A hunting lane that sees a header starts counting. The lane is locked (`lane_lock_o[i]`=1) once LOCK_GOOD consecutive headers have arrived exactly FRAME_LEN bytes apart. A miss before that point returns the lane to hunting.
- R3: A locked lane stays locked through up to LOCK_BAD-1 consecutive missing headers at the expected positions. It drops lock on the LOCK_BAD-th.
- R4: `lane_id_o[i*IDW +: IDW]` equals the last accepted marker of physical lane i modulo NUM_LANES, whatever the lane's physical position.
- R5: A slot counter advances every FRAME_LEN/NUM_LANES bytes and wraps at MARKER_MOD. A lane's epoch is (marker − slot) mod MARKER_MOD, taken when its marker byte arrives. Each locked lane gets a signed difference: its epoch minus the epoch of the lowest-indexed locked lane, modulo MARKER_MOD, folded into [−MARKER_MOD/2, MARKER_MOD/2−1]. `skew_o` is the maximum of these differences minus the minimum, in frame periods.
- R6: `skew_err_o` is 1 exactly when `skew_o` exceeds MARKER_MOD/2−1 (119 for a 240-value marker).
- R7: `id_err_o` is 1 when two locked lanes report the same logical number. Because NUM_LANES lanes that are all locked with no duplicates cover every number, this also catches a missing number.
- R8: `align_ok_o` is 1 only when all lanes are locked and neither error flag is raised. `skew_o`, `skew_err_o`, `id_err_o` and `align_ok_o` are registered one cycle behind the lane state.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | NUM_LANES*8 | One received byte per physical lane, lane i at bits [i*8 +: 8] |
| lane_lock_o | output | NUM_LANES | Per-lane lock flag |
| lane_id_o | output | NUM_LANES*IDW | Per-lane logical number, lane i at [i*IDW +: IDW] |
| skew_o | output | MW | Spread of lane epochs in frame periods |
| skew_err_o | output | 1 | Skew beyond the resolvable range |
| id_err_o | output | 1 | Duplicate logical number among locked lanes |
| align_ok_o | output | 1 | Lane group fully locked and consistent |

## Verification
The skew flag and the duplicate flag come out of the same evaluation register, so both can rise in the same cycle. The bench provokes this with one scenario that maps two physical lanes to the same logical number and also offsets one lane by exactly 120 frame periods. Both flags must read 1 together, and the alignment-valid flag must read 0. An exhaustive sweep over all lane permutations, with varied skews that include wrap-around cases, confirms that each flag is judged on its own in every other combination.

// File: rtl/lane_chk_pkg.sv
package lane_chk_pkg;
  localparam logic [7:0] HDR_A = 8'hF6;
  localparam logic [7:0] HDR_B = 8'h28;

  typedef enum logic [1:0] {
    FS_HUNT = 2'd0,
    FS_PRE  = 2'd1,
    FS_SYNC = 2'd2
  } fs_e;
endpackage

// File: rtl/lane_slot_timer.sv
module lane_slot_timer #(
  parameter int SLOT_LEN   = 816,
  parameter int MARKER_MOD = 240,
  localparam int SBW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1,
  localparam int MW  = $clog2(MARKER_MOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [MW-1:0] slot_o
);
  logic [SBW-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      slot_o <= '0;
    end else if (byte_q == SBW'(SLOT_LEN - 1)) begin
      byte_q <= '0;
      slot_o <= (slot_o == MW'(MARKER_MOD - 1)) ? '0 : slot_o + 1'b1;
    end else begin
      byte_q <= byte_q + 1'b1;
    end
  end
endmodule

// File: rtl/lane_framer.sv
module lane_framer import lane_chk_pkg::*; #(
  parameter int FRAME_LEN  = 16320,
  parameter int NUM_LANES  = 20,
  parameter int MARKER_MOD = 240,
  parameter int LOCK_GOOD  = 2,
  parameter int LOCK_BAD   = 5,
  localparam int CW  = $clog2(FRAME_LEN),
  localparam int MW  = $clog2(MARKER_MOD),
  localparam int IDW = $clog2(NUM_LANES),
  localparam int GW  = $clog2(LOCK_GOOD + 1),
  localparam int BW  = $clog2(LOCK_BAD + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [7:0]     byte_i,
  input  logic [MW-1:0]  slot_i,
  output logic           lock_o,
  output logic [IDW-1:0] id_o,
  output logic [MW-1:0]  epoch_o
);
  fs_e            st_q;
  logic [4:0][7:0] hist_q;
  logic [CW-1:0]  cnt_q;
  logic [GW-1:0]  good_q;
  logic [BW-1:0]  bad_q;
  logic           hit, due;
  logic [IDW-1:0] id_nxt;
  logic [MW-1:0]  ep_nxt;

  // hist_q[0] is the uncompared byte, byte_i is the marker
  assign hit = (hist_q[4] == HDR_A) && (hist_q[3] == HDR_A) &&
               (hist_q[2] == HDR_A) && (hist_q[1] == HDR_B);
  assign due = (cnt_q == '0);
  assign id_nxt = IDW'(int'(byte_i) % NUM_LANES);
  assign ep_nxt = MW'((int'(byte_i) + MARKER_MOD - int'(slot_i)) % MARKER_MOD);
  assign lock_o = (st_q == FS_SYNC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[3:0], byte_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_HUNT;
      cnt_q   <= '0;
      good_q  <= '0;
      bad_q   <= '0;
      id_o    <= '0;
      epoch_o <= '0;
    end else begin
      cnt_q <= (cnt_q == CW'(FRAME_LEN - 1)) ? '0 : cnt_q + 1'b1;
      unique case (st_q)
        FS_HUNT: begin
          if (hit) begin
            cnt_q   <= CW'(1);
            id_o    <= id_nxt;
            epoch_o <= ep_nxt;
            bad_q   <= '0;
            if (LOCK_GOOD <= 1) begin
              st_q <= FS_SYNC;
            end else begin
              st_q   <= FS_PRE;
              good_q <= GW'(1);
            end
          end
        end
        FS_PRE: begin
          if (due) begin
            if (hit) begin
              id_o    <= id_nxt;
              epoch_o <= ep_nxt;
              if (int'(good_q) + 1 >= LOCK_GOOD) st_q <= FS_SYNC;
              good_q <= good_q + 1'b1;
            end else begin
              st_q   <= FS_HUNT;
              good_q <= '0;
            end
          end
        end
        FS_SYNC: begin
          if (due) begin
            if (hit) begin
              bad_q   <= '0;
              id_o    <= id_nxt;
              epoch_o <= ep_nxt;
            end else if (int'(bad_q) + 1 >= LOCK_BAD) begin
              st_q   <= FS_HUNT;
              bad_q  <= '0;
              good_q <= '0;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end
        end
        default: st_q <= FS_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/lane_align_eval.sv
module lane_align_eval #(
  parameter int NUM_LANES  = 20,
  parameter int MARKER_MOD = 240,
  localparam int MW   = $clog2(MARKER_MOD),
  localparam int IDW  = $clog2(NUM_LANES),
  localparam int HALF = MARKER_MOD / 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_LANES-1:0]          lock_i,
  input  logic [NUM_LANES-1:0][IDW-1:0] id_i,
  input  logic [NUM_LANES-1:0][MW-1:0]  epoch_i,
  output logic [MW-1:0]                 skew_o,
  output logic                          skew_err_o,
  output logic                          id_err_o,
  output logic                          align_ok_o
);
  int      ref_ep, mx, mn, d;
  logic    dup;
  logic [MW-1:0] skew_nxt;
  logic    serr_nxt;

  always_comb begin
    ref_ep = 0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (lock_i[i]) ref_ep = int'(epoch_i[i]);
    end
    mx = 0;
    mn = 0;
    d  = 0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (lock_i[i]) begin
        d = (int'(epoch_i[i]) + MARKER_MOD - ref_ep) % MARKER_MOD;
        if (d >= HALF) d = d - MARKER_MOD;
        if (d > mx) mx = d;
        if (d < mn) mn = d;
      end
    end
    skew_nxt = MW'(mx - mn);
    serr_nxt = (mx - mn) > (HALF - 1);
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      for (int j = i + 1; j < NUM_LANES; j++) begin
        if (lock_i[i] && lock_i[j] && (id_i[i] == id_i[j])) dup = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skew_o     <= '0;
      skew_err_o <= 1'b0;
      id_err_o   <= 1'b0;
      align_ok_o <= 1'b0;
    end else begin
      skew_o     <= skew_nxt;
      skew_err_o <= serr_nxt;
      id_err_o   <= dup;
      align_ok_o <= (&lock_i) && !dup && !serr_nxt;
    end
  end
endmodule

// File: rtl/lane_id_skew_chk.sv
module lane_id_skew_chk #(
  parameter int NUM_LANES  = 20,
  parameter int FRAME_LEN  = 16320,
  parameter int MARKER_MOD = 240,
  parameter int LOCK_GOOD  = 2,
  parameter int LOCK_BAD   = 5,
  localparam int MW       = $clog2(MARKER_MOD),
  localparam int IDW      = $clog2(NUM_LANES),
  localparam int SLOT_LEN = FRAME_LEN / NUM_LANES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_LANES*8-1:0]   lane_data_i,
  output logic [NUM_LANES-1:0]     lane_lock_o,
  output logic [NUM_LANES*IDW-1:0] lane_id_o,
  output logic [MW-1:0]            skew_o,
  output logic                     skew_err_o,
  output logic                     id_err_o,
  output logic                     align_ok_o
);
  logic [MW-1:0]                 slot;
  logic [NUM_LANES-1:0][IDW-1:0] ids;
  logic [NUM_LANES-1:0][MW-1:0]  epochs;

  lane_slot_timer #(
    .SLOT_LEN  (SLOT_LEN),
    .MARKER_MOD(MARKER_MOD)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_o(slot)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_framer #(
      .FRAME_LEN (FRAME_LEN),
      .NUM_LANES (NUM_LANES),
      .MARKER_MOD(MARKER_MOD),
      .LOCK_GOOD (LOCK_GOOD),
      .LOCK_BAD  (LOCK_BAD)
    ) u_framer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .byte_i (lane_data_i[g*8 +: 8]),
      .slot_i (slot),
      .lock_o (lane_lock_o[g]),
      .id_o   (ids[g]),
      .epoch_o(epochs[g])
    );
    assign lane_id_o[g*IDW +: IDW] = ids[g];
  end

  lane_align_eval #(
    .NUM_LANES (NUM_LANES),
    .MARKER_MOD(MARKER_MOD)
  ) u_eval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (lane_lock_o),
    .id_i      (ids),
    .epoch_i   (epochs),
    .skew_o    (skew_o),
    .skew_err_o(skew_err_o),
    .id_err_o  (id_err_o),
    .align_ok_o(align_ok_o)
  );
endmodule

// File: rtl/lane_id_skew_chk_sva.sv
module lane_id_skew_chk_sva #(
  parameter int NUM_LANES  = 20,
  parameter int FRAME_LEN  = 16320,
  parameter int MARKER_MOD = 240,
  parameter int LOCK_BAD   = 5,
  localparam int MW   = $clog2(MARKER_MOD),
  localparam int HOLD = LOCK_BAD * FRAME_LEN - 1,
  localparam int HW   = $clog2(HOLD + 2)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LANES-1:0] lane_lock_o,
  input logic [MW-1:0]        skew_o,
  input logic                 skew_err_o,
  input logic                 id_err_o,
  input logic                 align_ok_o
);
  assert_align_all_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_ok_o |-> $past(&lane_lock_o));

  assert_skew_blocks_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skew_err_o |-> !align_ok_o);

  assert_dup_blocks_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_err_o |-> !align_ok_o);

  assert_align_skew_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_ok_o |-> (int'(skew_o) <= MARKER_MOD / 2 - 1));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_hold
    logic [HW-1:0] held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) held_q <= '0;
      else if (!lane_lock_o[g]) held_q <= '0;
      else if (held_q != HW'(HOLD)) held_q <= held_q + 1'b1;
    end
    // lock can only drop after LOCK_BAD full header periods of misses
    assert_lock_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lane_lock_o[g]) |-> ($past(held_q) == HW'(HOLD)));
  end
endmodule

bind lane_id_skew_chk lane_id_skew_chk_sva #(
  .NUM_LANES (NUM_LANES),
  .FRAME_LEN (FRAME_LEN),
  .MARKER_MOD(MARKER_MOD),
  .LOCK_BAD  (LOCK_BAD)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lane_lock_o(lane_lock_o),
  .skew_o     (skew_o),
  .skew_err_o (skew_err_o),
  .id_err_o   (id_err_o),
  .align_ok_o (align_ok_o)
);

// File: tb/lane_id_skew_chk_tb.sv
`timescale 1ns/1ps
module lane_id_skew_chk_tb;
  localparam int N    = 4;
  localparam int FL   = 24;
  localparam int MOD  = 240;
  localparam int P    = FL / N;
  localparam int IDW  = $clog2(N);
  localparam int MW   = $clog2(MOD);
  localparam int OFF  = MOD * P;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [N*8-1:0]     lane_data = '0;
  logic [N-1:0]       lane_lock;
  logic [N*IDW-1:0]   lane_id;
  logic [MW-1:0]      skew;
  logic               skew_err, id_err, align_ok;

  int total = 0;
  int bad   = 0;
  int t     = 0;
  int cfg_g [N];
  int cfg_s [N];
  bit cfg_c [N];

  always #4 clk = ~clk;

  lane_id_skew_chk #(
    .NUM_LANES(N), .FRAME_LEN(FL), .MARKER_MOD(MOD), .LOCK_GOOD(2), .LOCK_BAD(5)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lane_data_i(lane_data),
    .lane_lock_o(lane_lock), .lane_id_o(lane_id), .skew_o(skew),
    .skew_err_o(skew_err), .id_err_o(id_err), .align_ok_o(align_ok)
  );

  function automatic logic [7:0] lane_byte(int tt, int g, int s, bit c);
    int u, f, pos;
    u = tt + OFF - s * P;
    f = u / P;
    pos = u % P;
    if (f % N != g) return 8'h11;
    case (pos)
      0: return c ? 8'h00 : 8'hF6;
      1, 2: return 8'hF6;
      3: return 8'h28;
      4: return 8'h3C;  // uncompared byte, deliberately not 0x28 (R1)
      default: return 8'(f % MOD);
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_ni) t = 0;
    else t = t + 1;
    for (int l = 0; l < N; l++) lane_data[l*8 +: 8] = lane_byte(t, cfg_g[l], cfg_s[l], cfg_c[l]);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic exp_skew(output int sk, output bit er);
    int mx, mn, d;
    bit first;
    mx = 0; mn = 0; first = 1;
    for (int l = 0; l < N; l++) begin
      if (!cfg_c[l]) begin
        if (first) begin
          first = 0;
          for (int k = l; k < N; k++) begin
            if (!cfg_c[k]) begin
              d = ((cfg_s[l] - cfg_s[k]) % MOD + MOD) % MOD;
              if (d >= MOD / 2) d = d - MOD;
              if (d > mx) mx = d;
              if (d < mn) mn = d;
            end
          end
        end
      end
    end
    sk = mx - mn;
    er = sk > MOD / 2 - 1;
  endtask

  task automatic run_cfg(input int g0, g1, g2, g3, s0, s1, s2, s3);
    int sk;
    bit er, dup, all;
    cfg_g[0] = g0; cfg_g[1] = g1; cfg_g[2] = g2; cfg_g[3] = g3;
    cfg_s[0] = s0; cfg_s[1] = s1; cfg_s[2] = s2; cfg_s[3] = s3;
    do_reset();
    repeat (5 * FL) @(negedge clk);
    exp_skew(sk, er);
    dup = 0; all = 1;
    for (int l = 0; l < N; l++) begin
      if (cfg_c[l]) all = 0;
      for (int k = l + 1; k < N; k++)
        if (!cfg_c[l] && !cfg_c[k] && cfg_g[l] == cfg_g[k]) dup = 1;
    end
    for (int l = 0; l < N; l++) begin
      chk(lane_lock[l] == !cfg_c[l], "R2 lock", int'(lane_lock[l]), int'(!cfg_c[l]));
      if (!cfg_c[l])
        chk(int'(lane_id[l*IDW +: IDW]) == cfg_g[l], "R4 lane id",
            int'(lane_id[l*IDW +: IDW]), cfg_g[l]);
    end
    chk(int'(skew) == sk, "R5 skew", int'(skew), sk);
    chk(skew_err == er, "R6 skew_err", int'(skew_err), int'(er));
    chk(id_err == dup, "R7 id_err", int'(id_err), int'(dup));
    chk(align_ok == (all && !dup && !er), "R8 align_ok", int'(align_ok), int'(all && !dup && !er));
  endtask

  initial begin
    int p;
    for (int l = 0; l < N; l++) begin cfg_g[l] = l; cfg_s[l] = 0; cfg_c[l] = 0; end
    repeat (2) @(negedge clk);
    // R9: reset state
    chk(lane_lock == '0 && lane_id == '0 && skew == '0 && !skew_err && !id_err && !align_ok,
        "R9 reset", int'(lane_lock), 0);

    // exhaustive permutation sweep with varied skews (R1 R2 R4 R5 R6 R8)
    p = 0;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        for (int c = 0; c < N; c++)
          for (int d = 0; d < N; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              run_cfg(a, b, c, d, (p * 37) % MOD, (p * 11 + 53) % MOD,
                      (p * 29 + 7) % 120, (p * 5) % 60);
              p++;
            end

    // R6 boundaries and wrap
    run_cfg(0, 1, 2, 3, 0, 0, 0, 119);
    run_cfg(0, 1, 2, 3, 0, 0, 0, 120);
    run_cfg(2, 0, 3, 1, 119, 0, 0, 0);
    run_cfg(1, 3, 0, 2, 200, 0, 0, 0);
    run_cfg(3, 2, 1, 0, 5, 125, 5, 5);
    // R7 duplicate alone, then duplicate and skew error in the same evaluation
    run_cfg(0, 1, 1, 3, 0, 0, 0, 0);
    run_cfg(0, 1, 1, 3, 0, 0, 120, 0);

    // R2: a lane that never shows a valid header stays unlocked
    cfg_c[3] = 1;
    run_cfg(0, 1, 2, 3, 0, 0, 0, 0);
    cfg_c[3] = 0;

    // R3: lock survives 4 misses, drops on the 5th
    run_cfg(0, 1, 2, 3, 0, 0, 0, 0);
    while (t % FL != 12) @(negedge clk);
    cfg_c[1] = 1;
    repeat (4 * FL + 4) @(negedge clk);
    chk(lane_lock[1] == 1'b1, "R3 lock held after 4 misses", int'(lane_lock[1]), 1);
    chk(align_ok == 1'b1, "R3 align held after 4 misses", int'(align_ok), 1);
    repeat (FL) @(negedge clk);
    chk(lane_lock[1] == 1'b0, "R3 lock lost on 5th miss", int'(lane_lock[1]), 0);
    chk(align_ok == 1'b0, "R8 align drops with lock", int'(align_ok), 0);
    cfg_c[1] = 0;
    repeat (3 * FL + 10) @(negedge clk);
    chk(lane_lock[1] == 1'b1, "R2 relock", int'(lane_lock[1]), 1);
    chk(align_ok == 1'b1, "R8 align restored", int'(align_ok), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule